// File: doc/BRIEF.md
# Staggered four-slot ADC sequencer

This block sequences four overlapping conversions of one selected analog input. While enabled, a round begins by latching the input select. Four converter slots are then started one after another, each a quarter of the programmed conversion time after the one before it. As each converter reports done, its sample is steered into one of eight result registers. Inputs 0 to 3 use the lower bank of four and inputs 4 to 7 use the upper bank.

Once all four samples of a round are stored, the block pulses a completion interrupt and starts the next round on the same input without any action from software. The results of a new round overwrite the old ones whether or not they were read. Conversion stops only when software clears the enable. A round cut short this way raises no interrupt and keeps whatever results it had already stored.

Top module: `adc_stagger_seq`

## Requirements
- R1: While enable stays high, each round drives exactly one single-cycle start pulse on each of the four slots, and `slot_chan_o` carries the input latched for that round.
- R2: With Q = floor(conv_time_i / 4), the start of slot k comes k*Q cycles after the start of slot 0. Slot 0 starts in the cycle after the round's latch edge. When Q is 0, all four slots start in the same cycle.
- R3: Slot k's result goes to register k if the latched input is 0 to 3 (bit 2 clear) and to register 4+k if it is 4 to 7. Register i occupies `result_o[8*i+7:8*i]`.
- R4: `irq_o` is high for exactly one cycle. That cycle is the one in which the fourth result of the round first appears on `result_o`.
- R5: If enable is still high in the interrupt cycle and the one after it, slot 0 of the next round starts in the cycle after the interrupt.
- R6: While enable is low, no start pulse is issued and `result_o` does not change.
- R7: Each completed round overwrites the four registers of its bank with the new samples.
- R8: The input select is sampled only at the start of a round. A change during a round first appears on `slot_chan_o` and in bank steering in the next round.
- R9: Clearing enable during a round cancels it. Results already stored keep their values, no interrupt is raised for that round, and done responses that arrive later are not stored.
- R10: A done pulse on a slot with no conversion outstanding in the current round is ignored.
- R11: After reset, all result registers read 0, no start is issued and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; clearing it stops and cancels conversion |
| chan_sel_i | input | CH_W | Selected analog input, sampled at round start |
| conv_time_i | input | CNT_W | Conversion time in clock cycles |
| slot_start_o | output | 4 | Start pulse per converter slot |
| slot_chan_o | output | CH_W | Input the converters should sample this round |
| slot_done_i | input | 4 | Done pulse per converter slot |
| slot_data_i | input | 4*DATA_W | Sample per slot, slot k at bits [DATA_W*k +: DATA_W] |
| result_o | output | 8*DATA_W | Eight result registers, register i at [DATA_W*i +: DATA_W] |
| irq_o | output | 1 | One-cycle round-complete interrupt |

## Verification
The bench builds the block with DATA_W=8, CNT_W=8 and CH_W=3, so it uses 8-bit samples and both register banks. It runs conversion times of 16, 10 and 3. These give an exact quarter, a truncated quarter and a zero quarter in which all slots start together. Converter latencies are equal in some runs and run in reverse in others, so results arrive out of start order. One latency is longer than the cancel point, which exercises late done pulses after a cancel.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned SLOTS   = 4;
  localparam int unsigned NUM_RES = 2 * SLOTS;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [CH_W-1:0] chan_sel_i,
  input  logic            all_done_i,
  output logic            round_start_o,
  output logic            active_o,
  output logic [CH_W-1:0] chan_o,
  output logic            irq_o
);
  seq_state_e      state_q;
  logic [CH_W-1:0] chan_q;
  logic            irq_q;

  assign round_start_o = (state_q == ST_IDLE) && en_i;
  assign active_o      = (state_q == ST_RUN) && en_i;
  assign chan_o        = chan_q;
  assign irq_o         = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= active_o && all_done_i;
      unique case (state_q)
        ST_IDLE: if (en_i) begin
          state_q <= ST_RUN;
          chan_q  <= chan_sel_i;
        end
        ST_RUN: if (!en_i || all_done_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_stagger.sv
module adc_seq_stagger
  import adc_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] conv_time_i,
  output logic [SLOTS-1:0] start_o,
  output logic [SLOTS-1:0] issued_o
);
  localparam int unsigned THR_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [SLOTS-1:0] issued_q;
  logic [CNT_W-1:0] quarter;

  assign quarter  = conv_time_i >> 2;
  assign issued_o = issued_q;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [THR_W-1:0] thr;
    assign thr        = THR_W'(k) * {2'b00, quarter};
    assign start_o[k] = active_i && !issued_q[k] && ({2'b00, cnt_q} >= thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      issued_q <= '0;
    end else if (clear_i) begin
      cnt_q    <= '0;
      issued_q <= '0;
    end else if (active_i) begin
      issued_q <= issued_q | start_o;
      // freeze once every slot has been launched
      if (!(&(issued_q | start_o))) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_collect.sv
module adc_seq_collect
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             active_i,
  input  logic [SLOTS-1:0] issued_i,
  input  logic [SLOTS-1:0] done_i,
  output logic [SLOTS-1:0] wr_o,
  output logic             all_done_o
);
  logic [SLOTS-1:0] got_q;

  assign wr_o       = {SLOTS{active_i}} & issued_i & ~got_q & done_i;
  assign all_done_o = active_i && (&(got_q | wr_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       got_q <= '0;
    else if (clear_i)  got_q <= '0;
    else if (active_i) got_q <= got_q | wr_o;
  end
endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [SLOTS-1:0]          wr_i,
  input  logic                      upper_i,
  input  logic [SLOTS*DATA_W-1:0]   data_i,
  output logic [NUM_RES*DATA_W-1:0] result_o
);
  for (genvar i = 0; i < NUM_RES; i++) begin : g_reg
    localparam int unsigned SLOT = i % SLOTS;
    localparam logic        GRP  = (i >= SLOTS);
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              val_q <= '0;
      else if (wr_i[SLOT] && (upper_i == GRP))  val_q <= data_i[SLOT*DATA_W +: DATA_W];
    end
    assign result_o[i*DATA_W +: DATA_W] = val_q;
  end
endmodule

// File: rtl/adc_stagger_seq.sv
module adc_stagger_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CH_W   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [CH_W-1:0]           chan_sel_i,
  input  logic [CNT_W-1:0]          conv_time_i,
  output logic [SLOTS-1:0]          slot_start_o,
  output logic [CH_W-1:0]           slot_chan_o,
  input  logic [SLOTS-1:0]          slot_done_i,
  input  logic [SLOTS*DATA_W-1:0]   slot_data_i,
  output logic [NUM_RES*DATA_W-1:0] result_o,
  output logic                      irq_o
);
  logic             round_start, active, all_done;
  logic [SLOTS-1:0] issued, wr;

  adc_seq_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .chan_sel_i,
    .all_done_i   (all_done),
    .round_start_o(round_start),
    .active_o     (active),
    .chan_o       (slot_chan_o),
    .irq_o
  );

  adc_seq_stagger #(.CNT_W(CNT_W)) u_stagger (
    .clk_i, .rst_ni,
    .clear_i    (round_start),
    .active_i   (active),
    .conv_time_i,
    .start_o    (slot_start_o),
    .issued_o   (issued)
  );

  adc_seq_collect u_collect (
    .clk_i, .rst_ni,
    .clear_i   (round_start),
    .active_i  (active),
    .issued_i  (issued),
    .done_i    (slot_done_i),
    .wr_o      (wr),
    .all_done_o(all_done)
  );

  adc_seq_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_i    (wr),
    .upper_i (slot_chan_o[CH_W-1]),
    .data_i  (slot_data_i),
    .result_o
  );
endmodule

// File: rtl/adc_stagger_seq_chk.sv
module adc_stagger_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      en_i,
  input logic [SLOTS-1:0]          slot_start_o,
  input logic [NUM_RES*DATA_W-1:0] result_o,
  input logic                      irq_o
);
  assert_no_start_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> slot_start_o == '0);

  assert_hold_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(result_o));

  assert_irq_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en_i));

  assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && en_i) ##1 en_i |-> slot_start_o[0]);

  for (genvar k = 0; k < SLOTS; k++) begin : g_pulse
    assert_single_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_start_o[k] |=> !slot_start_o[k]);
  end
endmodule

bind adc_stagger_seq adc_stagger_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .slot_start_o(slot_start_o),
  .result_o    (result_o),
  .irq_o       (irq_o)
);

// File: tb/adc_stagger_seq_tb.sv
module adc_stagger_seq_tb;
  localparam int DW = 8, CW = 8, HW = 3;

  logic          clk = 1'b0, rst_ni = 1'b0, en = 1'b0;
  logic [HW-1:0] chan = 3'd2;
  logic [CW-1:0] conv = 8'd16;
  logic [3:0]    start, done = '0;
  logic [HW-1:0] schan;
  logic [4*DW-1:0] sdata = '0;
  logic [8*DW-1:0] res;
  logic          irq;

  always #5 clk = ~clk;

  adc_stagger_seq #(.DATA_W(DW), .CNT_W(CW), .CH_W(HW)) u_dut (
    .clk_i(clk), .rst_ni, .en_i(en), .chan_sel_i(chan), .conv_time_i(conv),
    .slot_start_o(start), .slot_chan_o(schan), .slot_done_i(done),
    .slot_data_i(sdata), .result_o(res), .irq_o(irq)
  );

  int total = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // converter responders
  int lat[4] = '{16, 16, 16, 16};
  int cd[4]  = '{0, 0, 0, 0};
  logic [3:0] inj = '0;
  logic [7:0] seed = 8'd1;

  // reference model state
  bit        m_run = 0, m_irq = 0;
  int        m_t = 0;
  bit [3:0]  m_iss = '0, m_got = '0;
  logic [HW-1:0] m_ch = '0;
  logic [7:0] m_res[8] = '{default: 8'h00};

  // observation
  int  cyc = 0, irq_cnt = 0;
  int  st_cnt[4] = '{0, 0, 0, 0};
  int  last_st[4] = '{0, 0, 0, 0};
  bit  saw4 = 0, prev_irq_en = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      automatic bit [3:0] exp_st;
      automatic logic [8*DW-1:0] exp_res;
      automatic int q = int'(conv) / 4;
      cyc++;
      for (int k = 0; k < 4; k++)
        exp_st[k] = m_run && en && !m_iss[k] && (m_t >= k * q);
      for (int i = 0; i < 8; i++) exp_res[i*8 +: 8] = m_res[i];
      chk(start == exp_st, "R2 start pattern", 64'(start), 64'(exp_st));
      chk(irq == m_irq, "R4 irq", 64'(irq), 64'(m_irq));
      chk(res == exp_res, "R3/R7 results", res, exp_res);
      if (m_run) chk(schan == m_ch, "R8 slot_chan", 64'(schan), 64'(m_ch));
      if (prev_irq_en && en) chk(start[0], "R5 restart", 64'(start[0]), 64'd1);
      prev_irq_en = irq && en;
      if (irq) irq_cnt++;
      if (start == 4'hF) saw4 = 1;
      for (int k = 0; k < 4; k++) if (start[k]) begin st_cnt[k]++; last_st[k] = cyc; end

      // converters
      done = '0;
      for (int k = 0; k < 4; k++) begin
        if (cd[k] > 0) begin
          cd[k]--;
          if (cd[k] == 0) begin
            done[k] = 1'b1;
            sdata[k*8 +: 8] = seed;
            seed = (seed == 8'hFF) ? 8'd1 : seed + 8'd1;
          end
        end else if (inj[k]) begin
          done[k] = 1'b1;
          sdata[k*8 +: 8] = 8'hEE;
        end
        if (start[k]) cd[k] = lat[k];
      end

      // model step for the coming edge
      if (!m_run) begin
        m_irq = 0;
        if (en) begin m_run = 1; m_t = 0; m_iss = '0; m_got = '0; m_ch = chan; end
      end else if (!en) begin
        m_run = 0; m_irq = 0;
      end else begin
        for (int k = 0; k < 4; k++)
          if (m_iss[k] && !m_got[k] && done[k]) begin
            m_res[(m_ch[2] ? 4 : 0) + k] = sdata[k*8 +: 8];
            m_got[k] = 1;
          end
        m_iss |= exp_st;
        m_t++;
        if (m_got == 4'hF) begin m_run = 0; m_irq = 1; end else m_irq = 0;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_irqs(input int n);
    automatic int tgt = irq_cnt + n;
    while (irq_cnt < tgt) @(posedge clk);
    #1;
  endtask

  task automatic wait_start(input int k);
    automatic int tgt = st_cnt[k] + 1;
    while (st_cnt[k] < tgt) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R4 act=hung exp=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    automatic logic [8*DW-1:0] snap;
    automatic int ic, n;
    step(3);
    rst_ni = 1'b1;
    #3;
    // R11 reset state
    chk(res == '0, "R11 results", res, 0);
    chk(irq == 1'b0, "R11 irq", 64'(irq), 0);
    chk(start == '0, "R11 start", 64'(start), 0);
    step(1);

    // R1/R7: three rounds, lower bank
    en = 1'b1;
    wait_irqs(3);
    for (int k = 0; k < 4; k++) chk(st_cnt[k] == 3, "R1 starts per slot", 64'(st_cnt[k]), 3);
    chk(res[63:32] == '0, "R3 upper bank untouched", res[63:32], 0);

    // R8: select changes mid-round, takes effect next round
    step(6);
    chan = 3'd5;
    wait_irqs(2);
    n = 0;
    for (int i = 4; i < 8; i++) if (res[i*8 +: 8] != 0) n++;
    chk(n == 4, "R3 upper bank written", 64'(n), 4);
    chk(schan == 3'd5, "R8 new select", 64'(schan), 5);

    // R2: truncated quarter, out-of-order completion
    conv = 8'd10;
    lat = '{20, 15, 10, 5};
    wait_irqs(2);
    chk(last_st[1] - last_st[0] == 2, "R2 q=2 slot1", 64'(last_st[1] - last_st[0]), 2);
    chk(last_st[3] - last_st[0] == 6, "R2 q=2 slot3", 64'(last_st[3] - last_st[0]), 6);

    // R9: cancel mid-round with two results stored
    conv = 8'd16;
    chan = 3'd1;
    lat = '{2, 2, 40, 40};
    wait_irqs(1);
    wait_start(3);
    en = 1'b0;
    ic = irq_cnt;
    step(2);
    snap = res;
    step(60);
    chk(irq_cnt == ic, "R9 no irq after cancel", 64'(irq_cnt), 64'(ic));
    chk(res == snap, "R9 results kept", res, snap);

    // R10/R6: spurious done while disabled
    inj = 4'hF;
    step(5);
    inj = '0;
    step(2);
    chk(res == snap, "R10 spurious done ignored", res, snap);
    n = st_cnt[0];
    step(5);
    chk(st_cnt[0] == n, "R6 no start when off", 64'(st_cnt[0]), 64'(n));

    // R2: zero quarter, all slots together
    conv = 8'd3;
    lat = '{4, 4, 4, 4};
    en = 1'b1;
    wait_irqs(1);
    en = 1'b0;
    chk(saw4, "R2 q=0 simultaneous start", 64'(saw4), 1);
    step(5);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule